// File: doc/BRIEF.md
# Clock Recovery Event Timestamp Counters

This block gathers the raw measurements used by adaptive clock recovery. It counts timing events arriving from the network side and, next to that count, keeps a prescaled count of the local reference clock. The block runs on that local clock. Each time an event is counted, the current local count is latched. Software can compare how many events arrived with how much local time passed between them, and so estimate the ratio of the two rates.

Two event sources exist: pulses that mark received timing reference cells, and 8 kHz frame marker pulses. A configuration input picks which one is counted. Both pulse inputs are asynchronous. Each passes through a synchroniser and a rising-edge detector, so every pulse counts exactly once whatever its length.

The event count and the latched local count are large, so software reads them over several accesses of a 16-bit register bus. To keep those reads coherent, a snapshot command copies both values into readable holding registers at once. The live counters keep running after a snapshot. Reads return the held copies until the next command.

Top module: `ref_timing_meter`

## Requirements
- R1: The event counter is EVT_W bits wide (16 by default). It increments by exactly one for each counted event and wraps from all-ones to zero without saturating.
- R2: With `src_sel` = 0 only rising edges on `cell_evt_i` are counted. With `src_sel` = 1 only rising edges on `frame_evt_i` are counted. Edges on the unselected input leave every readable value unchanged.
- R3: Each rising edge of the selected input counts once, however many cycles the input stays high. If the input is first high before clock edge c+1, the counter takes the new value at clock edge c+3, which is SYNC_STAGES+1 edges later.
- R4: The live local count increments once every 2^PRE_W clock cycles (8 by default). After n clock edges since reset release it holds floor(n / 2^PRE_W) modulo 2^LCL_W.
- R5: The latched local count changes only at the clock edge where an event is counted. It then takes the live local count as it stands after that same edge.
- R6: A one-cycle `snap_req` copies the event count and the latched local count together into the readable copies. Those copies stay unchanged until the next `snap_req`, while the live counters keep counting.
- R7: When an event is counted at the same clock edge as a `snap_req` is sampled, the snapshot holds the post-event values: the incremented event count and the newly latched local count.
- R8: A read is requested with `rd_en` = 1 and `rd_addr`, and `rd_data` shows the result after the next clock edge. The addresses are: 0 = event count, zero-extended; 1 = bits 15:0 of the held local count; 2 = bits LCL_W-1:16 of the held local count in its low bits, with the upper bits zero; 3 = zero. In a cycle after `rd_en` was 0, `rd_data` is zero.
- R9: After reset, every counter, latch and readable copy is zero, so all addresses read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock; also the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | Event source: 0 = cell pulses, 1 = frame markers |
| cell_evt_i | input | 1 | Asynchronous timing reference cell pulse |
| frame_evt_i | input | 1 | Asynchronous 8 kHz frame marker pulse |
| snap_req | input | 1 | One-cycle command that freezes both counts into the readable copies |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 16 | Read data, valid the cycle after the strobe |

## Verification
Counting an event and taking a snapshot can fall on the same clock edge, and that coincidence decides whether software sees pre-event or post-event values. The bench raises a cell pulse and then asserts `snap_req` in exactly the cycle whose closing edge is the one where the synchronised pulse is counted. It then reads back all three registers. A correct design returns the incremented event count together with the local time of that new event, both computed from the bench's own edge count. A stale snapshot shows the previous event's pair.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
   localparam int unsigned RD_AW   = 2;
   localparam int unsigned RD_DW   = 16;

   typedef enum logic [RD_AW-1:0] {
      RA_EVENTS  = 2'd0,
      RA_TIME_LO = 2'd1,
      RA_TIME_HI = 2'd2,
      RA_SPARE   = 2'd3
   } rd_sel_e;
endpackage

// File: rtl/rtm_edge_sync.sv
module rtm_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= '0;
         last_q <= 1'b0;
      end else begin
         chain  <= {chain[STAGES-2:0], async_i};
         last_q <= chain[STAGES-1];
      end
   end

   assign rise_o = chain[STAGES-1] & ~last_q;

   // R3
   single_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/rtm_prescale_count.sv
module rtm_prescale_count #(
   parameter int unsigned PRE_W = 3,
   parameter int unsigned LCL_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [LCL_W-1:0] lcnt_o,
   output logic [LCL_W-1:0] lcnt_nxt_o
);
   logic [PRE_W-1:0] div_q;
   logic             tick;

   assign tick       = &div_q;
   assign lcnt_nxt_o = tick ? lcnt_o + LCL_W'(1) : lcnt_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         lcnt_o <= '0;
      end else begin
         div_q  <= div_q + PRE_W'(1);
         lcnt_o <= lcnt_nxt_o;
      end
   end

   // R4
   lcnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q != '1) |=> $stable(lcnt_o));
   // R4
   lcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q == '1) |=> (lcnt_o == $past(lcnt_o) + LCL_W'(1)));
endmodule

// File: rtl/rtm_event_capture.sv
module rtm_event_capture #(
   parameter int unsigned EVT_W = 16,
   parameter int unsigned LCL_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic             snap_i,
   input  logic [LCL_W-1:0] lcnt_nxt_i,
   output logic [EVT_W-1:0] ev_snap_o,
   output logic [LCL_W-1:0] lc_snap_o
);
   logic [EVT_W-1:0] ev_q,   ev_nxt;
   logic [LCL_W-1:0] lcap_q, lcap_nxt;

   assign ev_nxt   = evt_i ? ev_q + EVT_W'(1) : ev_q;
   assign lcap_nxt = evt_i ? lcnt_nxt_i : lcap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q      <= '0;
         lcap_q    <= '0;
         ev_snap_o <= '0;
         lc_snap_o <= '0;
      end else begin
         ev_q   <= ev_nxt;
         lcap_q <= lcap_nxt;
         if (snap_i) begin
            ev_snap_o <= ev_nxt;
            lc_snap_o <= lcap_nxt;
         end
      end
   end

   // R1
   evt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> (ev_q == $past(ev_q) + EVT_W'(1)));
   // R1
   evt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_i |=> $stable(ev_q));
   // R5
   lcap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_i |=> $stable(lcap_q));
   // R6
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_i |=> ($stable(ev_snap_o) && $stable(lc_snap_o)));
   // R7
   snap_post_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i && snap_i) |=> (ev_snap_o == ev_q && lc_snap_o == lcap_q));
endmodule

// File: rtl/ref_timing_meter.sv
module ref_timing_meter #(
   parameter int unsigned EVT_W       = 16,
   parameter int unsigned LCL_W       = 24,
   parameter int unsigned PRE_W       = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        src_sel,
   input  logic        cell_evt_i,
   input  logic        frame_evt_i,
   input  logic        snap_req,
   input  logic        rd_en,
   input  logic [1:0]  rd_addr,
   output logic [15:0] rd_data
);
   import rtm_pkg::*;

   localparam int unsigned N_SRC = 2;
   localparam int unsigned HI_W  = LCL_W - RD_DW;

   initial begin
      assert (EVT_W >= 1 && EVT_W <= RD_DW)
         else $error("EVT_W must lie in 1..16");
      assert (LCL_W > RD_DW && LCL_W <= 2*RD_DW)
         else $error("LCL_W must lie in 17..32");
      assert (PRE_W >= 1) else $error("PRE_W must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic [N_SRC-1:0] raw_in, rise;
   logic             evt;
   logic [LCL_W-1:0] lcnt, lcnt_nxt, lc_snap;
   logic [EVT_W-1:0] ev_snap;
   logic [RD_DW-1:0] ev_word, hi_word, mux_word;

   assign raw_in = {frame_evt_i, cell_evt_i};

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      rtm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (raw_in[g]),
         .rise_o  (rise[g])
      );
   end

   assign evt = rise[src_sel];

   rtm_prescale_count #(.PRE_W(PRE_W), .LCL_W(LCL_W)) u_pre (
      .clk        (clk),
      .rst_n      (rst_n),
      .lcnt_o     (lcnt),
      .lcnt_nxt_o (lcnt_nxt)
   );

   rtm_event_capture #(.EVT_W(EVT_W), .LCL_W(LCL_W)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .snap_i     (snap_req),
      .lcnt_nxt_i (lcnt_nxt),
      .ev_snap_o  (ev_snap),
      .lc_snap_o  (lc_snap)
   );

   always_comb begin
      ev_word = '0;
      ev_word[EVT_W-1:0] = ev_snap;
      hi_word = '0;
      hi_word[HI_W-1:0] = lc_snap[LCL_W-1:RD_DW];
      unique case (rd_sel_e'(rd_addr))
         RA_EVENTS:  mux_word = ev_word;
         RA_TIME_LO: mux_word = lc_snap[RD_DW-1:0];
         RA_TIME_HI: mux_word = hi_word;
         default:    mux_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= rd_en ? mux_word : '0;
   end

   // R8
   rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rd_data == '0));
   // R8
   rd_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == RA_SPARE) |=> (rd_data == '0));
endmodule

// File: tb/tb_ref_timing_meter.sv
module tb_ref_timing_meter;
   localparam int EVT_W = 8;
   localparam int LCL_W = 24;
   localparam int PRE_W = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_sel = 1'b0;
   logic        cell_evt_i = 1'b0;
   logic        frame_evt_i = 1'b0;
   logic        snap_req = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  rd_addr = 2'd0;
   logic [15:0] rd_data;

   int ncyc = 0;
   int tests = 0;
   int fails = 0;
   int exp_ev = 0, exp_lc = 0, snap_ev = 0, snap_lc = 0;

   always #5 clk = ~clk;

   always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

   ref_timing_meter #(.EVT_W(EVT_W), .LCL_W(LCL_W), .PRE_W(PRE_W)) dut (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .cell_evt_i(cell_evt_i),
      .frame_evt_i(frame_evt_i), .snap_req(snap_req), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      rd_en = 1'b1;
      rd_addr = 2'(a);
      @(negedge clk);
      v = int'(rd_data);
      rd_en = 1'b0;
   endtask

   task automatic fire(input int line, input int hold);
      int c;
      @(negedge clk);
      if (line == 0) cell_evt_i = 1'b1; else frame_evt_i = 1'b1;
      c = ncyc;
      if ((line == 0) == (src_sel == 1'b0)) begin
         exp_ev = (exp_ev + 1) % (1 << EVT_W);
         exp_lc = ((c + 3) >> PRE_W) % (1 << LCL_W);
      end
      repeat (hold) @(negedge clk);
      cell_evt_i = 1'b0;
      frame_evt_i = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic snap();
      @(negedge clk);
      snap_req = 1'b1;
      @(negedge clk);
      snap_req = 1'b0;
      snap_ev = exp_ev;
      snap_lc = exp_lc;
   endtask

   task automatic check_all(input string tag);
      int v;
      rd(0, v); check({tag, " events"}, v, snap_ev);
      rd(1, v); check({tag, " time_lo"}, v, snap_lc & 32'hFFFF);
      rd(2, v); check({tag, " time_hi"}, v, snap_lc >> 16);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int v, c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state on all four addresses
      for (int a = 0; a < 4; a++) begin
         rd(a, v); check("R9 reset read", v, 0);
      end

      // R1 R3 R5: cell events of several pulse lengths, src_sel=0
      fire(0, 1); fire(0, 2); fire(0, 5);
      snap(); check_all("R3 cell pulses");

      // R2: frame markers ignored while cells selected
      fire(1, 1); fire(1, 3);
      snap(); check_all("R2 frame ignored");

      // R2: frame markers counted, cells ignored
      src_sel = 1'b1;
      fire(1, 2); fire(0, 2); fire(1, 1);
      snap(); check_all("R2 frame selected");
      src_sel = 1'b0;

      // R4: sweep event phase against the prescaler
      for (int ph = 0; ph < 8; ph++) begin
         repeat (ph) @(negedge clk);
         fire(0, 1);
         snap();
         rd(1, v); check("R4 local count phase", v, snap_lc & 32'hFFFF);
      end

      // R6: snapshot holds while live counters move on
      snap();
      fire(0, 1); fire(0, 4);
      repeat (20) @(negedge clk);
      check_all("R6 held copy");
      snap_ev = exp_ev; snap_lc = exp_lc;
      snap(); check_all("R6 live kept counting");

      // R7: event and snapshot on the same edge
      @(negedge clk);
      cell_evt_i = 1'b1;
      c = ncyc;
      exp_ev = (exp_ev + 1) % (1 << EVT_W);
      exp_lc = ((c + 3) >> PRE_W) % (1 << LCL_W);
      @(negedge clk);
      @(negedge clk);
      snap_req = 1'b1;
      @(negedge clk);
      snap_req = 1'b0;
      cell_evt_i = 1'b0;
      snap_ev = exp_ev; snap_lc = exp_lc;
      repeat (3) @(negedge clk);
      check_all("R7 coincident snapshot");

      // R1: event counter wrap
      for (int i = 0; i < 260; i++) fire(0, 1);
      snap(); check_all("R1 wrap");

      // R8: spare address and idle read data
      rd(3, v); check("R8 spare address", v, 0);
      @(negedge clk); check("R8 idle rd_data", int'(rd_data), 0);

      // R8: high word with nonzero upper bits of local count
      repeat (131200) @(negedge clk);
      fire(0, 1);
      snap(); check_all("R8 high word");
      check("R8 high word nonzero", int'(snap_lc >> 16) > 0 ? 1 : 0, 1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule